// File: doc/BRIEF.md
# I2C Controller Configuration Register

This block is the configuration word of an I2C controller. It sits on a plain single-register write bus and drives one decoded field per output port into the rest of the controller. Those fields are master enable, bus speed class, 7/10-bit addressing for the slave and master roles, repeated-start permission, slave disable, two STOP-detect qualifiers, transmit-empty control and receive-full bus hold.

The register can only be reconfigured while the controller is idle. A write that arrives while bit 0 of the controller enable input is high is dropped. Several bit positions are read-only. A parameter fixes their values, and no write changes them. The speed field never holds an illegal code: a write of 0, or of a value above the highest supported speed, stores that highest speed instead. Reads are side-effect free. The current word is always visible on the read-data port, and bits that have no meaning read as zero.

Top module: `i2c_cfg_reg`

## Requirements
- R1: After reset the read-data word has bit 0 (master enable) = 1, bits [2:1] (speed) = MAX_SPEED, bit 5 (restart enable) = 1 and bit 6 (slave disable) = 1. Bits 3, 4, 7, 8 and 9 are 0, and the read-only bits hold RO_VAL.
- R2: A write (`wr_i`=1) while `ctrl_en_i`=0 stores `wdata_i` bits 0, 3, 4, 5, 6, 7, 8 and 9 into the same positions. The result is visible on `rdata_o` one clock edge later.
- R3: A write while `ctrl_en_i`=1 leaves every bit of the register unchanged.
- R4: Speed codes 1 (standard, 100 kbit/s), 2 (fast / fast-plus) and 3 (high speed, 3.4 Mbit/s) that do not exceed MAX_SPEED are stored as written. A written code of 0, or a code above MAX_SPEED, is stored as MAX_SPEED.
- R5: Bits 10, 11, 16, 17, 18 and 19 are read-only. They always equal the matching bits of RO_VAL, whatever is written.
- R6: Bits 12 to 15 and 20 to 31 always read 0.
- R7: Each field output equals its register bit or bits: master 0, speed [2:1], slave 10-bit 3, master 10-bit 4, restart 5, slave disable 6, STOP-if-addressed 7, TX-empty control 8, RX-full hold 9, STOP-if-master-active 10.
- R8: With `wr_i`=0 the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| ctrl_en_i | input | 1 | Controller enabled; blocks writes when 1 |
| rdata_o | output | 32 | Current register word |
| master_en_o | output | 1 | Master role enabled |
| speed_o | output | 2 | Speed class, always 1..MAX_SPEED |
| slv_addr10_o | output | 1 | Slave answers 10-bit addresses |
| mst_addr10_o | output | 1 | Master starts with 10-bit addresses |
| restart_en_o | output | 1 | Repeated start allowed |
| slave_dis_o | output | 1 | Slave role disabled |
| stop_if_addr_o | output | 1 | STOP detect only when addressed |
| tx_empty_ctrl_o | output | 1 | Transmit-empty interrupt control |
| rx_hold_o | output | 1 | Hold bus when receive buffer is full |
| stop_if_mst_act_o | output | 1 | STOP detect qualifier for master (read-only) |

## Verification
The bench builds the block with MAX_SPEED=2, so code 3 is above the limit and code 0 is below it, and both clamp paths to 2 can be exercised. RO_VAL is set to 32'h000A_0C00, a mix of ones and zeros across the read-only positions. That exposes a read-only bit that a write overwrites, a constant that is dropped, and a bit that is wrongly left writable.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned SW = 10;  // stored bits [9:0]

  localparam int unsigned B_MST     = 0;
  localparam int unsigned B_SPD_LO  = 1;
  localparam int unsigned B_SPD_HI  = 2;
  localparam int unsigned B_SLV10   = 3;
  localparam int unsigned B_MST10   = 4;
  localparam int unsigned B_RESTART = 5;
  localparam int unsigned B_SLVDIS  = 6;
  localparam int unsigned B_STOPADR = 7;
  localparam int unsigned B_TXEMPTY = 8;
  localparam int unsigned B_RXHOLD  = 9;
  localparam int unsigned B_STOPMST = 10;

  localparam logic [SW-1:0] WR_MASK  = 10'h3F9;       // plain writable bits
  localparam logic [DW-1:0] RO_MASK  = 32'h000F_0C00;
  localparam logic [SW-1:0] RST_BITS = 10'h061;       // speed inserted separately

  typedef struct packed {
    logic       rx_hold;
    logic       tx_empty;
    logic       stop_adr;
    logic       slv_dis;
    logic       restart;
    logic       mst10;
    logic       slv10;
    logic [1:0] speed;
    logic       mst;
  } cfg_t;
endpackage

// File: rtl/i2c_cfg_speed_clamp.sv
module i2c_cfg_speed_clamp #(
  parameter int unsigned MAX_SPEED = 3
) (
  input  logic [1:0] code_i,
  output logic [1:0] code_o
);
  localparam logic [1:0] MaxCode = 2'(MAX_SPEED);

  always_comb begin
    if (code_i == 2'd0 || code_i > MaxCode) code_o = MaxCode;
    else                                    code_o = code_i;
  end
endmodule

// File: rtl/i2c_cfg_write_gate.sv
module i2c_cfg_write_gate
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned MAX_SPEED = 3
) (
  input  logic          wr_i,
  input  logic          ctrl_en_i,
  input  logic [SW-1:0] wdata_i,
  input  logic [SW-1:0] cur_i,
  output logic [SW-1:0] next_o
);
  logic       we;
  logic [1:0] spd_legal;

  assign we = wr_i & ~ctrl_en_i;

  i2c_cfg_speed_clamp #(.MAX_SPEED(MAX_SPEED)) u_clamp (
    .code_i (wdata_i[B_SPD_HI:B_SPD_LO]),
    .code_o (spd_legal)
  );

  for (genvar i = 0; i < SW; i++) begin : g_bit
    if (WR_MASK[i]) begin : g_wr
      assign next_o[i] = we ? wdata_i[i] : cur_i[i];
    end else begin : g_spd
      assign next_o[i] = we ? spd_legal[i-B_SPD_LO] : cur_i[i];
    end
  end
endmodule

// File: rtl/i2c_cfg_reg.sv
module i2c_cfg_reg
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned   MAX_SPEED = 3,
  parameter logic [31:0]   RO_VAL    = 32'h0000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        ctrl_en_i,
  output logic [31:0] rdata_o,
  output logic        master_en_o,
  output logic [1:0]  speed_o,
  output logic        slv_addr10_o,
  output logic        mst_addr10_o,
  output logic        restart_en_o,
  output logic        slave_dis_o,
  output logic        stop_if_addr_o,
  output logic        tx_empty_ctrl_o,
  output logic        rx_hold_o,
  output logic        stop_if_mst_act_o
);
  localparam logic [SW-1:0] RstVal = RST_BITS | (SW'(MAX_SPEED) << B_SPD_LO);
  localparam logic [DW-1:0] RoBits = RO_VAL & RO_MASK;

  logic [SW-1:0] cfg_q, cfg_d;
  cfg_t          cfg;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:SW];

  i2c_cfg_write_gate #(.MAX_SPEED(MAX_SPEED)) u_gate (
    .wr_i      (wr_i),
    .ctrl_en_i (ctrl_en_i),
    .wdata_i   (wdata_i[SW-1:0]),
    .cur_i     (cfg_q),
    .next_o    (cfg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= RstVal;
    else         cfg_q <= cfg_d;
  end

  assign cfg     = cfg_t'(cfg_q);
  assign rdata_o = {{(DW-SW){1'b0}}, cfg_q} | RoBits;

  assign master_en_o       = cfg.mst;
  assign speed_o           = cfg.speed;
  assign slv_addr10_o      = cfg.slv10;
  assign mst_addr10_o      = cfg.mst10;
  assign restart_en_o      = cfg.restart;
  assign slave_dis_o       = cfg.slv_dis;
  assign stop_if_addr_o    = cfg.stop_adr;
  assign tx_empty_ctrl_o   = cfg.tx_empty;
  assign rx_hold_o         = cfg.rx_hold;
  assign stop_if_mst_act_o = RoBits[B_STOPMST];
endmodule

// File: rtl/i2c_cfg_reg_chk.sv
module i2c_cfg_reg_chk #(
  parameter int unsigned MAX_SPEED = 3,
  parameter logic [31:0] RO_VAL    = 32'h0000_0000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic [31:0] wdata_i,
  input logic        ctrl_en_i,
  input logic [31:0] rdata_o,
  input logic [1:0]  speed_o
);
  localparam logic [31:0] RoM   = 32'h000F_0C00;
  localparam logic [31:0] UndM  = 32'hFFF0_F000;
  localparam logic [31:0] WrM   = 32'h0000_03F9;

  a_r3_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ctrl_en_i) |=> $stable(rdata_o));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(rdata_o));

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ctrl_en_i) |=> ((rdata_o & WrM) == ($past(wdata_i) & WrM)));

  a_r4_speed_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_o != 2'd0) && (32'(speed_o) <= MAX_SPEED));

  a_r5_ro_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & RoM) == (RO_VAL & RoM));

  a_r6_undef_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & UndM) == 32'h0);
endmodule

bind i2c_cfg_reg i2c_cfg_reg_chk #(.MAX_SPEED(MAX_SPEED), .RO_VAL(RO_VAL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .ctrl_en_i (ctrl_en_i),
  .rdata_o   (rdata_o),
  .speed_o   (speed_o)
);

// File: tb/i2c_cfg_reg_bench.sv
`timescale 1ns/1ps
module i2c_cfg_reg_bench;
  localparam int unsigned MAXS = 2;
  localparam logic [31:0] ROV  = 32'h000A_0C00;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        ctrl_en_i = 1'b0;
  logic [31:0] rdata_o;
  logic        master_en_o, slv_addr10_o, mst_addr10_o, restart_en_o, slave_dis_o;
  logic        stop_if_addr_o, tx_empty_ctrl_o, rx_hold_o, stop_if_mst_act_o;
  logic [1:0]  speed_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model;

  always #2.5 clk_i = ~clk_i;

  i2c_cfg_reg #(.MAX_SPEED(MAXS), .RO_VAL(ROV)) u_i2c_cfg_reg (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .ctrl_en_i, .rdata_o,
    .master_en_o, .speed_o, .slv_addr10_o, .mst_addr10_o, .restart_en_o,
    .slave_dis_o, .stop_if_addr_o, .tx_empty_ctrl_o, .rx_hold_o, .stop_if_mst_act_o
  );

  function automatic logic [1:0] clamp(input logic [1:0] c);
    return (c == 2'd0 || 32'(c) > MAXS) ? 2'(MAXS) : c;
  endfunction

  function automatic logic [31:0] next_val(input logic [31:0] cur, input logic wr,
                                           input logic en, input logic [31:0] wd);
    logic [31:0] n;
    n = cur;
    if (wr && !en) begin
      n = (cur & ~32'h0000_03FF) | (wd & 32'h0000_03F9);
      n[2:1] = clamp(wd[2:1]);
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_fields(input string req);
    check(req, {21'd0, stop_if_mst_act_o, rx_hold_o, tx_empty_ctrl_o, stop_if_addr_o,
                slave_dis_o, restart_en_o, mst_addr10_o, slv_addr10_o, speed_o, master_en_o},
          {21'd0, model[10:0]});
  endtask

  task automatic step(input logic wr, input logic en, input logic [31:0] wd, input string req);
    wr_i = wr; ctrl_en_i = en; wdata_i = wd;
    @(negedge clk_i);
    model = next_val(model, wr, en, wd);
    check(req, rdata_o, model);
  endtask

  initial begin
    #200_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (2) @(negedge clk_i);
    model = 32'h000A_0C65;
    check("R1 reset word", rdata_o, model);
    check_fields("R7 reset fields");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 idle after reset", rdata_o, model);

    // R4 each speed code while idle
    for (int c = 0; c < 4; c++) begin
      step(1'b1, 1'b0, 32'h0000_0000 | (32'(c) << 1), "R4 speed clamp");
      check("R4 speed field", {30'd0, speed_o}, {30'd0, (c == 0 || c > 2) ? 2'd2 : 2'(c)});
    end
    // R2 all writable bits set, R5/R6 hostile write
    step(1'b1, 1'b0, 32'hFFFF_FFFF, "R2 R5 R6 full write");
    check_fields("R7 after full write");
    step(1'b1, 1'b0, 32'h0000_0000, "R2 clear write");
    check_fields("R7 after clear");
    // R3 locked write
    step(1'b1, 1'b1, 32'hFFFF_FFFF, "R3 locked write ignored");
    step(1'b1, 1'b1, 32'h0000_0002, "R3 locked speed write ignored");
    step(1'b0, 1'b0, 32'hFFFF_FFFF, "R8 no strobe hold");

    for (int i = 0; i < 400; i++) begin
      step(1'($urandom), 1'($urandom), $urandom, "R2 R3 R4 R5 R6 random");
      if (i % 16 == 0) check_fields("R7 random fields");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule